// File: doc/BRIEF.md
# Prioritized Vectored Interrupt Controller

This block collects six interrupt requests (two external lines, three timers and a serial port whose receive and transmit flags are merged into one request). It gates them with a master enable and one enable bit per source, and ranks them by a programmable priority level. When the core signals an instruction boundary and some request outranks everything already being serviced, the block grants it. The grant is a one-cycle acknowledge pulse, the granted source index and a fixed vector address.

Priority works in one of two modes. In two-level mode each source has one priority bit. In four-level mode it has a pair of bits, one taken from each of two priority registers. A 4-bit in-service mask records which levels have open handlers, so handlers can nest up to four deep. A return-from-interrupt strobe closes the most urgent open level. Software sets the enable and priority registers through a small write-only register port. The CPU, its stack handling and the peripherals themselves are not part of this block.

Top module: `prio_vec_intc`

## Requirements
- R1: After reset the enable and both priority registers are zero, `ackValid` is 0, `vecAddr` is 0x0000, `ackSrc` is 0 and `inService` is 0.
- R2: The enable register (`regSel`=0) holds the master enable in bit 7. While bit 7 is 0, no request is granted, whatever bits 5..0 hold.
- R3: Source indices are 0 ext0, 1 timer0, 2 ext1, 3 timer1, 4 serial, 5 timer2. Enable-register bit i gates source i, and a request whose bit is 0 is never granted.
- R4: A grant raises `ackValid` for exactly the cycle after the boundary edge. In that cycle `ackSrc` is the index and `vecAddr` is 0x0003 + 8 × index, which gives 0x0003, 0x000B, 0x0013, 0x001B, 0x0023 and 0x002B.
- R5: A grant happens only at a clock edge where `instrBoundary` is 1. Pending requests wait while it is 0.
- R6: With `fourLevelMode`=1, the level of source i is {high-register bit i (`regSel`=2), low-register bit i (`regSel`=1)}. That gives 0 to 3, and the highest level wins.
- R7: With `fourLevelMode`=0, the level of source i is the low-register bit alone (0 or 1), and the high register has no effect.
- R8: Requests at the same level are ranked by index, and the lowest index wins.
- R9: A request is granted only if its level is strictly above the highest set bit of `inService`. An open level-3 handler is never preempted.
- R10: A grant sets the `inService` bit of the granted level, so four nested handlers give `inService`=4'hF.
- R11: `retiStrobe` clears the highest set bit of `inService`. No grant happens at an edge where `retiStrobe` is 1, even if `instrBoundary` is 1.
- R12: The serial request is `serRxFlag` OR `serTxFlag`. A grant does not clear it, so a request still held after the return is granted again at the next boundary.
- R13: A register write with `regSel`=3 changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regWrEn | input | 1 | Register write strobe |
| regSel | input | 2 | 0 enable, 1 low priority, 2 high priority, 3 none |
| regWrData | input | 8 | Register write data |
| fourLevelMode | input | 1 | 1 selects four levels, 0 selects two |
| extReq | input | 2 | External requests, bit 0 = ext0 |
| tmrReq | input | 3 | Timer requests, bit n = timer n |
| serRxFlag | input | 1 | Serial receive flag |
| serTxFlag | input | 1 | Serial transmit flag |
| instrBoundary | input | 1 | Instruction boundary strobe |
| retiStrobe | input | 1 | Return-from-interrupt strobe |
| ackValid | output | 1 | One-cycle grant pulse |
| ackSrc | output | 3 | Granted source index |
| vecAddr | output | 16 | Vector address of the last grant |
| inService | output | 4 | Open handler levels, one bit per level |

## Verification
Every result here appears one clock edge after its cause. A grant shows on `ackValid`, `ackSrc`, `vecAddr` and `inService` just after the edge that sampled `instrBoundary`. A return shows on `inService` after the edge that sampled `retiStrobe`. A register write first affects arbitration at the edge after the one that stored it. The bench drives inputs on falling edges, and its reference model updates on the rising edge from the inputs it samples there. It compares all outputs on the next falling edge, so each expectation is read exactly one edge after its stimulus.

// File: rtl/prio_vec_intc_pkg.sv
package prio_vec_intc_pkg;
  localparam int NUM_LVL = 4;
  localparam int LVL_W   = $clog2(NUM_LVL);

  typedef enum logic [1:0] {
    SEL_ENABLE  = 2'd0,
    SEL_PRIO_LO = 2'd1,
    SEL_PRIO_HI = 2'd2,
    SEL_NONE    = 2'd3
  } regSel_e;

  typedef struct packed {
    logic accept;
    logic retire;
  } ctlStrobes_t;
endpackage

// File: rtl/prio_vec_intc_ctl.sv
module prio_vec_intc_ctl
  import prio_vec_intc_pkg::*;
(
  input  logic        instrBoundary,
  input  logic        retiStrobe,
  input  logic        winValid,
  input  logic        topActive,
  output ctlStrobes_t strobes
);
  // a return takes the slot of the boundary: nothing is granted alongside it
  always_comb begin
    strobes.retire = retiStrobe & topActive;
    strobes.accept = instrBoundary & winValid & ~retiStrobe;
  end
endmodule

// File: rtl/prio_vec_intc_dp.sv
module prio_vec_intc_dp
  import prio_vec_intc_pkg::*;
#(
  parameter int NUM_SRC    = 6,
  parameter int ADDR_W     = 16,
  parameter int VEC_BASE   = 3,
  parameter int VEC_STRIDE = 8,
  localparam int REG_W     = NUM_SRC + 2,
  localparam int IDX_W     = $clog2(NUM_SRC)
)(
  input  logic               clk,
  input  logic               rstN,
  input  logic               regWrEn,
  input  logic [1:0]         regSel,
  input  logic [REG_W-1:0]   regWrData,
  input  logic               fourLevelMode,
  input  logic [NUM_SRC-1:0] srcReq,
  input  ctlStrobes_t        strobes,
  output logic               winValid,
  output logic               topActive,
  output logic               globalEn,
  output logic               ackValid,
  output logic [IDX_W-1:0]   ackSrc,
  output logic [ADDR_W-1:0]  vecAddr,
  output logic [NUM_LVL-1:0] inService
);
  logic [REG_W-1:0]   enReg;
  logic [NUM_SRC-1:0] prioLo;
  logic [NUM_SRC-1:0] prioHi;
  logic [LVL_W-1:0]   srcLevel [NUM_SRC];
  logic [NUM_SRC-1:0] eligible;
  logic [LVL_W-1:0]   topLevel;
  logic [LVL_W-1:0]   winLevel;
  logic [IDX_W-1:0]   winIdx;

  // register port; the bit below the master enable is never stored
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      enReg  <= '0;
      prioLo <= '0;
      prioHi <= '0;
    end else if (regWrEn) begin
      case (regSel_e'(regSel))
        SEL_ENABLE:  enReg  <= {regWrData[REG_W-1], 1'b0, regWrData[NUM_SRC-1:0]};
        SEL_PRIO_LO: prioLo <= regWrData[NUM_SRC-1:0];
        SEL_PRIO_HI: prioHi <= regWrData[NUM_SRC-1:0];
        default: ;
      endcase
    end
  end

  assign globalEn = enReg[REG_W-1];

  // most urgent open level
  always_comb begin
    topActive = |inService;
    topLevel  = '0;
    for (int l = 0; l < NUM_LVL; l++)
      if (inService[l]) topLevel = LVL_W'(l);
  end

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
    assign srcLevel[g] = {fourLevelMode & prioHi[g], prioLo[g]};
    assign eligible[g] = srcReq[g] & enReg[g] & globalEn &
                         (~topActive | (srcLevel[g] > topLevel));
  end

  // strictly-higher replacement keeps the lowest index on ties
  always_comb begin
    winValid = 1'b0;
    winLevel = '0;
    winIdx   = '0;
    for (int i = 0; i < NUM_SRC; i++) begin
      if (eligible[i] && (!winValid || srcLevel[i] > winLevel)) begin
        winValid = 1'b1;
        winLevel = srcLevel[i];
        winIdx   = IDX_W'(i);
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ackValid  <= 1'b0;
      ackSrc    <= '0;
      vecAddr   <= '0;
      inService <= '0;
    end else begin
      ackValid <= strobes.accept;
      if (strobes.accept) begin
        ackSrc              <= winIdx;
        vecAddr             <= ADDR_W'(VEC_BASE + VEC_STRIDE * int'(winIdx));
        inService[winLevel] <= 1'b1;
      end else if (strobes.retire) begin
        inService[topLevel] <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/prio_vec_intc.sv
module prio_vec_intc
  import prio_vec_intc_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        regWrEn,
  input  logic [1:0]  regSel,
  input  logic [7:0]  regWrData,
  input  logic        fourLevelMode,
  input  logic [1:0]  extReq,
  input  logic [2:0]  tmrReq,
  input  logic        serRxFlag,
  input  logic        serTxFlag,
  input  logic        instrBoundary,
  input  logic        retiStrobe,
  output logic        ackValid,
  output logic [2:0]  ackSrc,
  output logic [15:0] vecAddr,
  output logic [3:0]  inService
);
  localparam int NUM_SRC = 6;

  logic [NUM_SRC-1:0] srcReq;
  logic               winValid;
  logic               topActive;
  logic               globalEn;
  ctlStrobes_t        strobes;

  // index order doubles as polling order
  assign srcReq = {tmrReq[2], serRxFlag | serTxFlag, tmrReq[1],
                   extReq[1], tmrReq[0], extReq[0]};

  prio_vec_intc_ctl ctl_i (
    .instrBoundary(instrBoundary),
    .retiStrobe   (retiStrobe),
    .winValid     (winValid),
    .topActive    (topActive),
    .strobes      (strobes)
  );

  prio_vec_intc_dp #(
    .NUM_SRC(NUM_SRC), .ADDR_W(16), .VEC_BASE(3), .VEC_STRIDE(8)
  ) dp_i (
    .clk          (clk),
    .rstN         (rstN),
    .regWrEn      (regWrEn),
    .regSel       (regSel),
    .regWrData    (regWrData),
    .fourLevelMode(fourLevelMode),
    .srcReq       (srcReq),
    .strobes      (strobes),
    .winValid     (winValid),
    .topActive    (topActive),
    .globalEn     (globalEn),
    .ackValid     (ackValid),
    .ackSrc       (ackSrc),
    .vecAddr      (vecAddr),
    .inService    (inService)
  );
endmodule

// File: rtl/prio_vec_intc_chk.sv
module prio_vec_intc_chk (
  input logic        clk,
  input logic        rstN,
  input logic        instrBoundary,
  input logic        retiStrobe,
  input logic        globalEn,
  input logic        ackValid,
  input logic [15:0] vecAddr,
  input logic [3:0]  inService
);
  a_r5_grant_at_boundary: assert property (@(posedge clk) disable iff (!rstN)
    ackValid |-> $past(instrBoundary));

  a_r2_grant_needs_master: assert property (@(posedge clk) disable iff (!rstN)
    ackValid |-> $past(globalEn));

  a_r11_no_grant_on_return: assert property (@(posedge clk) disable iff (!rstN)
    $past(retiStrobe) |-> !ackValid);

  a_r9_top_level_kept: assert property (@(posedge clk) disable iff (!rstN)
    $past(inService[3]) |-> !ackValid);

  a_r10_grant_opens_level: assert property (@(posedge clk) disable iff (!rstN)
    ackValid |-> $countones(inService) == $countones($past(inService)) + 1);

  a_r11_return_closes_level: assert property (@(posedge clk) disable iff (!rstN)
    ($past(retiStrobe) && $past(inService) != 4'd0) |->
      $countones(inService) + 1 == $countones($past(inService)));

  a_r4_vector_slot: assert property (@(posedge clk) disable iff (!rstN)
    ackValid |-> (vecAddr[2:0] == 3'd3 && vecAddr <= 16'h002B));
endmodule

bind prio_vec_intc prio_vec_intc_chk chk_i (
  .clk          (clk),
  .rstN         (rstN),
  .instrBoundary(instrBoundary),
  .retiStrobe   (retiStrobe),
  .globalEn     (globalEn),
  .ackValid     (ackValid),
  .vecAddr      (vecAddr),
  .inService    (inService)
);

// File: tb/prio_vec_intc_tb_top.sv
`timescale 1ns/1ps
module prio_vec_intc_tb_top;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic regWrEn = 1'b0;
  logic [1:0] regSel = '0;
  logic [7:0] regWrData = '0;
  logic fourLevelMode = 1'b1;
  logic [1:0] extReq = '0;
  logic [2:0] tmrReq = '0;
  logic serRxFlag = 1'b0, serTxFlag = 1'b0;
  logic instrBoundary = 1'b0, retiStrobe = 1'b0;
  logic ackValid;
  logic [2:0] ackSrc;
  logic [15:0] vecAddr;
  logic [3:0] inService;

  int nChk = 0, nBad = 0;
  string curReq = "R1";
  bit done = 1'b0;

  always #4 clk = ~clk;

  prio_vec_intc dut_i (.*);

  // behavioural reference
  int mEn = 0, mLo = 0, mHi = 0, mSrc = 0, mVec = 0;
  bit mAck = 0;
  bit [3:0] mIs = 0;
  always @(posedge clk) begin : model
    int top, best, bestLvl, lvl;
    bit [5:0] req;
    if (!rstN) begin
      mEn = 0; mLo = 0; mHi = 0; mSrc = 0; mVec = 0; mAck = 0; mIs = 0;
    end else begin
      req = {tmrReq[2], serRxFlag | serTxFlag, tmrReq[1], extReq[1], tmrReq[0], extReq[0]};
      top = -1;
      for (int l = 0; l < 4; l++) if (mIs[l]) top = l;
      mAck = 0;
      if (retiStrobe) begin
        if (top >= 0) mIs[top] = 0;
      end else if (instrBoundary && mEn[7]) begin
        best = -1; bestLvl = -1;
        for (int i = 0; i < 6; i++) begin
          if (req[i] && mEn[i]) begin
            lvl = fourLevelMode ? (mHi[i] * 2 + mLo[i]) : mLo[i];
            if (lvl > top && lvl > bestLvl) begin best = i; bestLvl = lvl; end
          end
        end
        if (best >= 0) begin
          mAck = 1; mSrc = best; mVec = 3 + 8 * best; mIs[bestLvl] = 1;
        end
      end
      if (regWrEn) begin
        case (regSel)
          2'd0: mEn = regWrData & 8'hBF;
          2'd1: mLo = regWrData;
          2'd2: mHi = regWrData;
          default: ;
        endcase
      end
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    nChk++;
    if (!ok) begin
      nBad++;
      $display("FAIL %s act=0x%0h exp=0x%0h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rstN && !done) begin
      chk(ackValid == mAck, {curReq, " ackValid"}, ackValid, mAck);
      chk(inService == mIs, {curReq, " inService"}, inService, mIs);
      chk(vecAddr == mVec[15:0], {curReq, " vecAddr"}, vecAddr, mVec);
      chk(ackSrc == mSrc[2:0], {curReq, " ackSrc"}, ackSrc, mSrc);
    end
  end

  task automatic tick(); @(negedge clk); endtask

  task automatic wr(input logic [1:0] s, input logic [7:0] d);
    tick(); regWrEn = 1; regSel = s; regWrData = d;
    tick(); regWrEn = 0;
  endtask

  task automatic bnd(); tick(); instrBoundary = 1; tick(); instrBoundary = 0; endtask
  task automatic ret(); tick(); retiStrobe = 1; tick(); retiStrobe = 0; endtask

  task automatic expGrant(input string tag, input int vec, input int isv);
    bnd();
    chk(ackValid == 1, tag, ackValid, 1);
    chk(vecAddr == vec[15:0], tag, vecAddr, vec);
    chk(inService == isv[3:0], tag, inService, isv);
  endtask

  task automatic expNone(input string tag);
    bnd();
    chk(ackValid == 0, tag, ackValid, 0);
  endtask

  task automatic summary();
    done = 1;
    $display("  test done: total=%0d bad=%0d", nChk, nBad);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    nBad++;
    $display("FAIL watchdog all-reqs act=hung exp=finished");
    summary();
    $finish;
  end

  initial begin
    repeat (3) tick();
    rstN = 1;
    tick();
    curReq = "R1";
    chk(ackValid == 0 && vecAddr == 0 && inService == 0 && ackSrc == 0, "R1 reset",
        {ackValid, vecAddr, inService}, 0);

    curReq = "R2";
    wr(0, 8'h3F); extReq = 2'b01;
    expNone("R2 master enable off");

    curReq = "R3";
    wr(0, 8'h81); extReq = 2'b00; tmrReq = 3'b001;
    expNone("R3 disabled source");
    curReq = "R4"; extReq = 2'b01;
    expGrant("R4 ext0 vector", 'h0003, 'b0001);
    chk(ackSrc == 0, "R4 ext0 index", ackSrc, 0);
    tick();
    chk(ackValid == 0, "R4 single-cycle pulse", ackValid, 0);
    extReq = 0; tmrReq = 0;
    curReq = "R11"; ret();
    chk(inService == 0, "R11 return clears", inService, 0);

    curReq = "R5";
    wr(0, 8'h84); extReq = 2'b10;
    repeat (5) tick();
    chk(ackValid == 0 && inService == 0, "R5 waits for boundary", ackValid, 0);
    expGrant("R5 ext1 at boundary", 'h0013, 'b0001);
    chk(ackSrc == 2, "R5 ext1 index", ackSrc, 2);
    ret(); extReq = 0;

    curReq = "R6";
    wr(0, 8'hBF); wr(1, 8'h24); wr(2, 8'h10);
    serRxFlag = 1; tmrReq = 3'b100;
    expGrant("R6 serial level 2 wins", 'h0023, 'b0100);
    curReq = "R9";
    expNone("R9 lower level held off");
    wr(2, 8'h14); extReq = 2'b10;
    expGrant("R9 level 3 preempts", 'h0013, 'b1100);
    expNone("R9 level 3 not preempted");
    curReq = "R11";
    tick(); retiStrobe = 1; instrBoundary = 1;
    tick(); retiStrobe = 0; instrBoundary = 0;
    chk(ackValid == 0 && inService == 4'b0100, "R11 return beats boundary", inService, 4'b0100);
    ret();
    chk(inService == 0, "R11 second return", inService, 0);
    serRxFlag = 0; tmrReq = 0; extReq = 0;

    curReq = "R8";
    wr(1, 8'h00); wr(2, 8'h00);
    tmrReq = 3'b011; serTxFlag = 1;
    expGrant("R8 lowest index on tie", 'h000B, 'b0001);
    ret(); tmrReq = 0; serTxFlag = 0;

    curReq = "R7";
    wr(0, 8'h89); wr(1, 8'h08); wr(2, 8'h01);
    extReq = 2'b01; tmrReq = 3'b010;
    expGrant("R7 four-level ext0 level 2", 'h0003, 'b0100);
    ret();
    fourLevelMode = 0;
    expGrant("R7 two-level timer1 wins", 'h001B, 'b0010);
    ret(); fourLevelMode = 1; extReq = 0; tmrReq = 0;

    curReq = "R12";
    wr(0, 8'h90); wr(1, 8'h00); wr(2, 8'h00);
    serTxFlag = 1;
    expGrant("R12 tx request", 'h0023, 'b0001);
    ret();
    expGrant("R12 held flag granted again", 'h0023, 'b0001);
    ret(); serTxFlag = 0; serRxFlag = 1;
    expGrant("R12 rx request", 'h0023, 'b0001);
    ret(); serRxFlag = 0;

    curReq = "R10";
    wr(0, 8'h8F); wr(1, 8'h0A); wr(2, 8'h0C);
    extReq = 2'b01;
    expGrant("R10 depth 1", 'h0003, 'b0001);
    tmrReq = 3'b001;
    expGrant("R10 depth 2", 'h000B, 'b0011);
    extReq = 2'b11;
    expGrant("R10 depth 3", 'h0013, 'b0111);
    tmrReq = 3'b011;
    expGrant("R10 depth 4", 'h001B, 'b1111);
    extReq = 0; tmrReq = 0;
    repeat (4) ret();
    chk(inService == 0, "R10 unwound", inService, 0);

    curReq = "R13";
    wr(0, 8'h81); wr(3, 8'h00);
    extReq = 2'b01;
    expGrant("R13 select 3 ignored", 'h0003, 'b0001);
    ret(); extReq = 0;

    repeat (3) tick();
    summary();
    $finish;
  end
endmodule